// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives one short packet onto the D+/D- pair of a low-speed USB device and then hands the bus back. When the controller pulses a start request, the block first sets both line outputs to the idle J state. It then enables the drivers and leads with one J bit time. Next it sends the sync byte and the payload bytes LSB first. The bits are NRZI-encoded, with a stuffed toggle after every run of six ones. The packet closes with the end-of-packet sequence, after which the drivers are switched off.

Payload bytes come from a valid/ready byte stream. A length input says how many payload bytes follow the sync byte. A handshake mode instead sends the sync byte and one PID byte taken from a side input, without touching the stream. The output enable and the two line levels are separate outputs, so an external tristate pad can be modelled. A device address waiting on its own input becomes the active address when a data packet ends, but not when a handshake ends.

The bit clock is a single-cycle enable from an integer divider inside the block. With a 250 MHz clock, the default divide of 167 gives about 1.497 Mbit/s. That is well inside the 1.5 % rate tolerance of a low-speed link.

Top module: `lsusb_tx`

## Requirements
- R1: While reset is held and right after it is released, dp_out, dm_out, drv_en, tx_busy and tx_ready are 0 and addr_cur is 0.
- R2: On the cycle after an accepted tx_start, the lines show J (dp_out=0, dm_out=1) with drv_en still 0. drv_en rises one cycle later with J held. The first K of the sync byte appears BIT_DIV+1 clock edges after the edge that accepted tx_start.
- R3: The first byte sent is the sync value 0x80. It is followed by the payload bytes in stream order, each byte sent LSB first.
- R4: NRZI coding: a 0 bit toggles the line state and a 1 bit keeps it. J is dp_out=0/dm_out=1 and K is dp_out=1/dm_out=0. Both lines are never high together.
- R5: After six consecutive 1 bits, one extra toggle is sent. The run count carries across byte boundaries, is cleared at packet start, and also applies after the last payload bit, before the end of packet.
- R6: A data packet carries tx_len payload bytes. A tx_len of 0 is treated as 1, and any tx_len above MAX_BYTES-1 (11) is treated as 11.
- R7: With tx_hs=1 at start, the packet is sync plus tx_pid, and tx_ready stays 0 for the whole packet.
- R8: tx_ready is 1 only while payload bytes are still owed and the one-byte holding buffer is empty. A byte is taken on a cycle where tx_valid and tx_ready are both 1, and the number of bytes taken equals the effective length.
- R9: While drv_en is 1, every line state lasts a whole multiple of BIT_DIV clock cycles, and each bit lasts exactly BIT_DIV cycles.
- R10: End of packet is SE0 (both lines 0) for two bit times, then J for one bit time. After that, drv_en drops and both lines go to 0 in the same cycle.
- R11: addr_cur takes the value of addr_next on the cycle drv_en drops after a data packet, and keeps its value after a handshake packet.
- R12: tx_busy is 1 from the cycle after an accepted start until the drivers are released. A tx_start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start request, taken only while idle |
| tx_hs | input | 1 | Handshake mode: send sync plus tx_pid only |
| tx_pid | input | 8 | PID byte for handshake mode |
| tx_len | input | LEN_W (4) | Payload byte count for data mode |
| tx_data | input | 8 | Payload byte from the stream |
| tx_valid | input | 1 | Stream byte valid |
| tx_ready | output | 1 | Block can take a stream byte |
| tx_busy | output | 1 | A packet is in progress |
| addr_next | input | ADDR_W (7) | Pending device address |
| addr_cur | output | ADDR_W (7) | Active device address |
| dp_out | output | 1 | D+ line level |
| dm_out | output | 1 | D- line level |
| drv_en | output | 1 | Line driver enable |

## Verification
A scoreboard checks every bit-centre line sample against a symbol list built from the bytes by an independent NRZI and stuffing model. The payloads are chosen to separate faults. Runs of 0xFF that span byte boundaries show whether the stuffing history is carried across bytes or wrongly cleared at each byte. Zero and alternating bytes make the line toggle on almost every bit, which exposes bit-order or polarity mistakes without any stuffing. A single 0xFC payload ends on six ones, so it shows whether a stuff bit is placed before SE0. Handshake packets are run in between data packets with different pending addresses, together with out-of-range lengths and a start pulse in mid-packet. These cases separate the address commit, the length clamp and the start filter.

// File: rtl/lsusb_tx_pkg.sv
package lsusb_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LEAD,
    ST_DATA,
    ST_EOP1,
    ST_EOP2,
    ST_EOPJ
  } tx_state_t;

  // Line state as driven to the pads: enable plus the two levels.
  typedef struct packed {
    logic en;
    logic dp;
    logic dm;
  } line_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int         STUFF_RUN = 6;
  localparam int         RUN_W     = $clog2(STUFF_RUN + 1);

  localparam line_t LINE_OFF  = line_t'{en: 1'b0, dp: 1'b0, dm: 1'b0};
  localparam line_t LINE_PREJ = line_t'{en: 1'b0, dp: 1'b0, dm: 1'b1};
  localparam line_t LINE_J    = line_t'{en: 1'b1, dp: 1'b0, dm: 1'b1};
  localparam line_t LINE_SE0  = line_t'{en: 1'b1, dp: 1'b0, dm: 1'b0};

endpackage

// File: rtl/lsusb_tx_tick.sv
module lsusb_tx_tick #(
  parameter int BIT_DIV = 167
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (BIT_DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_div
      localparam int             CW   = $clog2(BIT_DIV);
      localparam logic [CW-1:0]  LAST = CW'(BIT_DIV - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        if (!run)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/lsusb_tx_feed.sv
// One-byte holding buffer between the byte stream and the serializer.
// If the stream falls behind, zero bits are sent in place of the missing byte.
module lsusb_tx_feed #(
  parameter int MAX_BYTES = 12,
  localparam int LEN_W    = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             init_hs,
  input  logic [7:0]       init_pid,
  input  logic [LEN_W-1:0] init_len,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             take,
  output logic             more,
  output logic [7:0]       byte_out
);

  localparam int MAX_PAY = MAX_BYTES - 1;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l == '0)               return LEN_W'(1);
    else if (int'(l) > MAX_PAY) return LEN_W'(MAX_PAY);
    else                       return l;
  endfunction

  logic [7:0]       hold_q, hold_d;
  logic             full_q, full_d;
  logic [LEN_W-1:0] owe_q, owe_d;
  logic             accept;

  assign tx_ready = (owe_q != '0) && !full_q;
  assign accept   = tx_ready && tx_valid;
  assign more     = full_q || (owe_q != '0);
  assign byte_out = full_q ? hold_q : (accept ? tx_data : 8'h00);

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    owe_d  = owe_q;
    if (init) begin
      if (init_hs) begin
        hold_d = init_pid;
        full_d = 1'b1;
        owe_d  = '0;
      end else begin
        full_d = 1'b0;
        owe_d  = clamp_len(init_len);
      end
    end else if (take) begin
      if (full_d) full_d = 1'b0;
      else if (owe_q != '0) owe_d = owe_q - LEN_W'(1);
    end else if (accept) begin
      hold_d = tx_data;
      full_d = 1'b1;
      owe_d  = owe_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      owe_q  <= '0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      owe_q  <= owe_d;
    end
  end

endmodule

// File: rtl/lsusb_tx_ser.sv
// Shifts bytes out LSB first, counts runs of ones and tracks the NRZI level
// (level 1 = J). One symbol per step.
module lsusb_tx_ser
  import lsusb_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       step,
  input  logic [7:0] byte_in,
  input  logic       more,
  output logic       nxt_level,
  output logic       take,
  output logic       fin
);

  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bidx_q, bidx_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             drained_q, drained_d;
  logic             lvl_q, lvl_d;
  logic             stuff;

  assign stuff     = (run_q == RUN_W'(STUFF_RUN));
  assign fin       = drained_q && !stuff;
  assign take      = step && !stuff && !drained_q && (bidx_q == 3'd7) && more;
  assign nxt_level = lvl_d;

  always_comb begin
    sh_d      = sh_q;
    bidx_d    = bidx_q;
    run_d     = run_q;
    drained_d = drained_q;
    lvl_d     = lvl_q;
    if (init) begin
      sh_d      = SYNC_BYTE;
      bidx_d    = '0;
      run_d     = '0;
      drained_d = 1'b0;
      lvl_d     = 1'b1;
    end else if (step) begin
      if (stuff) begin
        lvl_d = ~lvl_q;
        run_d = '0;
      end else begin
        lvl_d = sh_q[0] ? lvl_q : ~lvl_q;
        run_d = sh_q[0] ? run_q + RUN_W'(1) : '0;
        if (bidx_q == 3'd7) begin
          bidx_d = '0;
          if (more) sh_d = byte_in;
          else      drained_d = 1'b1;
        end else begin
          sh_d   = {1'b0, sh_q[7:1]};
          bidx_d = bidx_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      bidx_q    <= '0;
      run_q     <= '0;
      drained_q <= 1'b0;
      lvl_q     <= 1'b1;
    end else begin
      sh_q      <= sh_d;
      bidx_q    <= bidx_d;
      run_q     <= run_d;
      drained_q <= drained_d;
      lvl_q     <= lvl_d;
    end
  end

endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
  import lsusb_tx_pkg::*;
#(
  parameter int  BIT_DIV   = 167,
  parameter int  MAX_BYTES = 12,
  parameter int  ADDR_W    = 7,
  localparam int LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_hs,
  input  logic [7:0]        tx_pid,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_busy,
  input  logic [ADDR_W-1:0] addr_next,
  output logic [ADDR_W-1:0] addr_cur,
  output logic              dp_out,
  output logic              dm_out,
  output logic              drv_en
);

  tx_state_t         st_q, st_d;
  line_t             line_q, line_d;
  logic              hs_q, hs_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic       tick, run;
  logic       start_ok;
  logic       ser_step, ser_take, ser_fin, ser_lvl;
  logic       feed_more;
  logic [7:0] feed_byte;

  assign run      = (st_q != ST_IDLE) && (st_q != ST_PRE);
  assign start_ok = (st_q == ST_IDLE) && tx_start;
  assign ser_step = tick && ((st_q == ST_LEAD) || (st_q == ST_DATA)) && !ser_fin;

  lsusb_tx_tick #(.BIT_DIV(BIT_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  lsusb_tx_feed #(.MAX_BYTES(MAX_BYTES)) u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (start_ok),
    .init_hs  (tx_hs),
    .init_pid (tx_pid),
    .init_len (tx_len),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .take     (ser_take),
    .more     (feed_more),
    .byte_out (feed_byte)
  );

  lsusb_tx_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (start_ok),
    .step      (ser_step),
    .byte_in   (feed_byte),
    .more      (feed_more),
    .nxt_level (ser_lvl),
    .take      (ser_take),
    .fin       (ser_fin)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    line_d = line_q;
    hs_d   = hs_q;
    addr_d = addr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_start) begin
          st_d   = ST_PRE;
          line_d = LINE_PREJ;   // levels first, drivers later
          hs_d   = tx_hs;
        end
      end
      ST_PRE: begin
        st_d   = ST_LEAD;
        line_d = LINE_J;
      end
      ST_LEAD, ST_DATA: begin
        if (tick) begin
          if (ser_fin) begin
            st_d   = ST_EOP1;
            line_d = LINE_SE0;
          end else begin
            st_d   = ST_DATA;
            line_d = line_t'{en: 1'b1, dp: ~ser_lvl, dm: ser_lvl};
          end
        end
      end
      ST_EOP1: begin
        if (tick) begin
          st_d   = ST_EOP2;
          line_d = LINE_SE0;
        end
      end
      ST_EOP2: begin
        if (tick) begin
          st_d   = ST_EOPJ;
          line_d = LINE_J;
        end
      end
      ST_EOPJ: begin
        if (tick) begin
          st_d   = ST_IDLE;
          line_d = LINE_OFF;
          if (!hs_q) addr_d = addr_next;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        line_d = LINE_OFF;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      line_q <= LINE_OFF;
      hs_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      line_q <= line_d;
      hs_q   <= hs_d;
      addr_q <= addr_d;
    end
  end

  assign tx_busy  = (st_q != ST_IDLE);
  assign dp_out   = line_q.dp;
  assign dm_out   = line_q.dm;
  assign drv_en   = line_q.en;
  assign addr_cur = addr_q;

endmodule

// File: rtl/lsusb_tx_chk.sv
module lsusb_tx_chk #(
  parameter int BIT_DIV = 167,
  parameter int ADDR_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              tx_busy,
  input logic              dp_out,
  input logic              dm_out,
  input logic              drv_en,
  input logic [ADDR_W-1:0] addr_cur
);

  logic [1:0]  prev_line_q;
  logic [15:0] gap_q;

  // Cycles since the last line change while driving.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_line_q <= '0;
      gap_q       <= '0;
    end else begin
      prev_line_q <= {dp_out, dm_out};
      if (!drv_en)                            gap_q <= '0;
      else if ({dp_out, dm_out} != prev_line_q) gap_q <= 16'd1;
      else                                    gap_q <= gap_q + 16'd1;
    end
  end

  assert_preset_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> ($past(dm_out) && !$past(dp_out)));

  assert_no_se1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_out && dm_out));

  assert_bit_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && ({dp_out, dm_out} != prev_line_q)) |->
      ((gap_q != 16'd0) && ((int'(gap_q) % BIT_DIV) == 0)));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> (!dp_out && !dm_out && $past(dm_out) && !$past(dp_out)));

  assert_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !dp_out);

  assert_addr_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cur != $past(addr_cur)) |-> $fell(drv_en));

  assert_busy_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> tx_busy);

  assert_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_busy);

endmodule

bind lsusb_tx lsusb_tx_chk #(.BIT_DIV(BIT_DIV), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_ready (tx_ready),
  .tx_busy  (tx_busy),
  .dp_out   (dp_out),
  .dm_out   (dm_out),
  .drv_en   (drv_en),
  .addr_cur (addr_cur)
);

// File: tb/sim_lsusb_tx.sv
`timescale 1ns/1ps
module sim_lsusb_tx;

  localparam int D  = 20;
  localparam int MB = 12;
  localparam int LW = 4;
  localparam int AW = 7;

  logic          clk;
  logic          rst_n;
  logic          tx_start, tx_hs, tx_valid;
  logic [7:0]    tx_pid, tx_data;
  logic [LW-1:0] tx_len;
  logic          tx_ready, tx_busy;
  logic [AW-1:0] addr_next, addr_cur;
  logic          dp_out, dm_out, drv_en;

  lsusb_tx #(.BIT_DIV(D), .MAX_BYTES(MB), .ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_hs     (tx_hs),
    .tx_pid    (tx_pid),
    .tx_len    (tx_len),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_busy   (tx_busy),
    .addr_next (addr_next),
    .addr_cur  (addr_cur),
    .dp_out    (dp_out),
    .dm_out    (dm_out),
    .drv_en    (drv_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int taken = 0;
  int ready_hi = 0;
  int pkts_seen = 0;
  logic [2:0] exp_q[$];
  logic [7:0] data_q[$];
  logic [2:0] code;
  logic       acc_pend = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Independent model: {drv_en, dp, dm} per bit time, from lead J to release.
  task automatic push_expected(input logic [7:0] pl[$]);
    logic [7:0] all[$];
    logic lvl;
    int run;
    all = pl;
    all.push_front(8'h80);
    lvl = 1'b1;
    run = 0;
    exp_q.push_back(3'b101);
    foreach (all[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (!all[k][i]) begin lvl = ~lvl; run = 0; end
        else run++;
        exp_q.push_back({1'b1, ~lvl, lvl});
        if (run == 6) begin
          lvl = ~lvl;
          run = 0;
          exp_q.push_back({1'b1, ~lvl, lvl});
        end
      end
    end
    exp_q.push_back(3'b100);
    exp_q.push_back(3'b100);
    exp_q.push_back(3'b101);
    exp_q.push_back(3'b000);
  endtask

  // Stream source
  initial begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (acc_pend) begin
        void'(data_q.pop_front());
        taken++;
      end
      tx_valid = (data_q.size() > 0);
      tx_data  = tx_valid ? data_q[0] : 8'h00;
      acc_pend = tx_valid && tx_ready;
    end
  end

  initial forever begin
    @(negedge clk);
    if (tx_ready === 1'b1) ready_hi++;
  end

  // Monitor: sample each bit time at its centre and compare with the queue.
  initial begin
    forever begin
      @(negedge clk);
      if (drv_en === 1'b1 && exp_q.size() > 0) begin
        repeat (D/2) @(negedge clk);
        while (exp_q.size() > 0) begin
          code = exp_q.pop_front();
          check("R3 R4 R5 R9 R10 line symbol", {drv_en, dp_out, dm_out}, code);
          if (code == 3'b000) break;
          repeat (D) @(negedge clk);
        end
        pkts_seen++;
      end
    end
  end

  task automatic send_pkt(input logic hs, input logic [7:0] pid, input logic [LW-1:0] len,
                          input logic [7:0] pl[$], input logic poke);
    logic [7:0] model[$];
    int t0, p0, k;
    if (hs) model.push_back(pid);
    else    model = pl;
    @(negedge clk);
    push_expected(model);
    if (!hs) foreach (pl[i]) data_q.push_back(pl[i]);
    t0 = taken;
    p0 = pkts_seen;
    ready_hi = 0;
    tx_hs    = hs;
    tx_pid   = pid;
    tx_len   = len;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    check("R2 preset J before enable", {drv_en, dp_out, dm_out}, 3'b001);
    check("R12 busy after start", tx_busy, 1);
    @(negedge clk);
    check("R2 enable with J", {drv_en, dp_out, dm_out}, 3'b101);
    k = 2;
    while (dp_out !== 1'b1 && k < 4*D) begin
      @(negedge clk);
      k++;
    end
    check("R2 first K latency", k, D + 2);
    if (poke) begin
      repeat (5*D) @(negedge clk);
      tx_hs    = 1'b1;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      tx_hs    = 1'b0;
      check("R12 busy during packet", tx_busy, 1);
    end
    while (pkts_seen == p0) @(negedge clk);
    check("R12 idle after release", tx_busy, 0);
    check("R8 ready low after packet", tx_ready, 0);
    check("R6 R8 bytes taken", taken - t0, hs ? 0 : pl.size());
    if (hs) check("R7 ready never high in handshake", ready_hi, 0);
    repeat (2) @(negedge clk);
    check("R12 start while busy ignored", tx_busy, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] pl[$];
    rst_n     = 1'b0;
    tx_start  = 1'b0;
    tx_hs     = 1'b0;
    tx_pid    = 8'h00;
    tx_len    = '0;
    addr_next = 7'h2A;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {dp_out, dm_out, drv_en, tx_busy, tx_ready}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release outputs", {dp_out, dm_out, drv_en, tx_busy, tx_ready}, 5'b0);
    check("R1 address reset", addr_cur, 0);

    // Handshake ACK: no address commit
    pl = {};
    send_pkt(1'b1, 8'hD2, 4'd0, pl, 1'b0);
    check("R11 no commit after handshake", addr_cur, 0);

    // Ones spanning byte boundaries
    pl = {8'hC3, 8'hFF, 8'hFF, 8'h7F};
    send_pkt(1'b0, 8'h00, 4'd4, pl, 1'b0);
    check("R11 commit after data", addr_cur, 7'h2A);

    // Dense toggling, plus start pulse mid-packet
    pl = {8'h00, 8'h55, 8'hAA};
    send_pkt(1'b0, 8'h00, 4'd3, pl, 1'b1);

    // Six trailing ones: stuff before SE0
    pl = {8'hFC};
    send_pkt(1'b0, 8'h00, 4'd1, pl, 1'b0);

    // Length above maximum clamps to 11
    pl = {};
    for (int i = 0; i < 11; i++) pl.push_back(8'(i * 37 + 5));
    send_pkt(1'b0, 8'h00, 4'd15, pl, 1'b0);

    // Length zero treated as one
    pl = {8'h3C};
    send_pkt(1'b0, 8'h00, 4'd0, pl, 1'b0);

    // New pending address; handshake keeps the old one
    addr_next = 7'h15;
    pl = {};
    send_pkt(1'b1, 8'h5A, 4'd5, pl, 1'b0);
    check("R11 handshake keeps address", addr_cur, 7'h2A);

    pl = {8'h01};
    send_pkt(1'b0, 8'h00, 4'd1, pl, 1'b0);
    check("R11 data commits new address", addr_cur, 7'h15);

    summary();
    $finish;
  end

endmodule